// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Enable Selector

This block turns the processor's power mode into clock enables. It gives one enable for each peripheral and one enable for the CPU and memory clock. Each of the three power modes (run, sleep and deep sleep) has its own bank of peripheral gating bits. The current mode arrives already decoded. An auto-gating control bit chooses between two sources for the low-power enables: the bank that belongs to the low-power mode, or the run-mode bank.

A single write port fills the banks. Every write passes through a fixed capability mask, so a bit that stands for an absent peripheral can never be set. A read port returns the value that was stored after masking. The outputs are registered. Clock-tree cells and glitch-free gating cells sit outside this block and consume the enables it produces.

Top module: `pwr_clk_gate_sel`

## Requirements
- R1: While and after reset, all three banks read zero, every peripheral enable is 0 and the core enable is 0.
- R2: With mode code 0 (run), the core enable is 1 and the peripheral enables equal the run bank. Both appear at the clock edge after the mode is presented.
- R3: With mode codes 1, 2 or 3, the core enable is 0 from the edge after the mode is presented.
- R4: With mode code 1 (sleep) and auto-gating at 1, the peripheral enables equal the sleep bank.
- R5: With mode code 2 (deep sleep) and auto-gating at 1, the peripheral enables equal the deep-sleep bank. Mode code 3 behaves exactly as code 2.
- R6: With any mode code other than 0 and auto-gating at 0, the peripheral enables equal the run bank.
- R7: A write with bank select 0 (run), 1 (sleep) or 2 (deep sleep) stores the write data ANDed with CAP_MASK. Reading with the same select returns that stored value. A read with select 3 returns zero.
- R8: A write with bank select 3, or with the write strobe at 0, changes no bank.
- R9: A bank write takes effect on the bank at the write edge and on the enable outputs at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Power mode: 0 run, 1 sleep, 2 deep sleep, 3 deep sleep |
| auto_gate_i | input | 1 | 1 selects the mode's own bank in low-power modes |
| wr_en_i | input | 1 | Bank write strobe |
| wr_sel_i | input | 2 | Bank to write: 0 run, 1 sleep, 2 deep, 3 none |
| wr_data_i | input | NUM_PERIPH | Write data, masked by CAP_MASK |
| rd_sel_i | input | 2 | Bank to read back |
| rd_data_o | output | NUM_PERIPH | Stored value of the selected bank |
| periph_en_o | output | NUM_PERIPH | Registered per-peripheral clock enables |
| core_en_o | output | 1 | Registered CPU/memory clock enable |

## Verification
A bank write and a mode change can land in the same cycle. The bench provokes this in two ways. First, it writes the sleep bank while the block already sits in sleep with auto-gating set. Second, it writes the run bank in the same cycle that the mode returns to run. In both cases the first output edge must show the new mode applied to the old bank contents, and the following edge must show the newly written and masked value. The bench judges each edge against its own model of the banks.

// File: rtl/pcg_pkg.sv
// Package: shared encodings for the power-mode clock enable selector.
// Assumes the mode input is already decoded into a 2-bit code.
package pcg_pkg;

    typedef enum logic [1:0] {
        MODE_RUN      = 2'd0,
        MODE_SLEEP    = 2'd1,
        MODE_DEEP     = 2'd2,
        MODE_DEEP_ALT = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        BANK_RUN   = 2'd0,
        BANK_SLEEP = 2'd1,
        BANK_DEEP  = 2'd2,
        BANK_NONE  = 2'd3
    } bank_e;

    localparam int unsigned BANK_CNT = 3;

endpackage

// File: rtl/pcg_bank_regs.sv
// Module: pcg_bank_regs
// Holds one gating bank per power mode, and provides a masked write port
// and a read port. Bits cleared in CAP_MASK can never be stored.
// Assumes a single writer. Select 3 addresses no bank.
module pcg_bank_regs
    import pcg_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 8,
    parameter logic [NUM_PERIPH-1:0] CAP_MASK = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_sel_i,
    input  logic [NUM_PERIPH-1:0] wr_data_i,
    input  logic [1:0]            rd_sel_i,
    output logic [NUM_PERIPH-1:0] rd_data_o,
    output logic [NUM_PERIPH-1:0] run_q_o,
    output logic [NUM_PERIPH-1:0] slp_q_o,
    output logic [NUM_PERIPH-1:0] dsl_q_o
);

    localparam int unsigned SEL_W = 2;

    logic [NUM_PERIPH-1:0] bank_q [BANK_CNT];
    logic [NUM_PERIPH-1:0] masked_wdata;

    // Apply the capability mask before anything is stored.
    assign masked_wdata = wr_data_i & CAP_MASK;

    for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(b);

        // Store masked write data when this bank is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else if (wr_en_i && (wr_sel_i == MY_SEL)) begin
                bank_q[b] <= masked_wdata;
            end
        end
    end

    // Return the stored value of the selected bank, or zero for select 3.
    always_comb begin
        unique case (bank_e'(rd_sel_i))
            BANK_RUN:   rd_data_o = bank_q[0];
            BANK_SLEEP: rd_data_o = bank_q[1];
            BANK_DEEP:  rd_data_o = bank_q[2];
            default:    rd_data_o = '0;
        endcase
    end

    assign run_q_o = bank_q[0];
    assign slp_q_o = bank_q[1];
    assign dsl_q_o = bank_q[2];

endmodule

// File: rtl/pcg_mode_mux.sv
// Module: pcg_mode_mux
// Combinational choice of the active bank and the core enable from the
// power mode and the auto-gating bit. Assumes codes 2 and 3 are both
// deep sleep.
module pcg_mode_mux
    import pcg_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 8
) (
    input  logic [1:0]            mode_i,
    input  logic                  auto_gate_i,
    input  logic [NUM_PERIPH-1:0] run_q_i,
    input  logic [NUM_PERIPH-1:0] slp_q_i,
    input  logic [NUM_PERIPH-1:0] dsl_q_i,
    output logic [NUM_PERIPH-1:0] periph_en_d_o,
    output logic                  core_en_d_o
);

    // Pick the bank, falling back to the run bank when auto-gating is off.
    always_comb begin
        unique case (pmode_e'(mode_i))
            MODE_RUN: begin
                core_en_d_o   = 1'b1;
                periph_en_d_o = run_q_i;
            end
            MODE_SLEEP: begin
                core_en_d_o   = 1'b0;
                periph_en_d_o = auto_gate_i ? slp_q_i : run_q_i;
            end
            default: begin
                core_en_d_o   = 1'b0;
                periph_en_d_o = auto_gate_i ? dsl_q_i : run_q_i;
            end
        endcase
    end

endmodule

// File: rtl/pcg_out_reg.sv
// Module: pcg_out_reg
// Output register stage for the enables. It adds one cycle of latency
// and clears both enables during reset.
module pcg_out_reg #(
    parameter int unsigned NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_en_d_i,
    input  logic                  core_en_d_i,
    output logic [NUM_PERIPH-1:0] periph_en_o,
    output logic                  core_en_o
);

    // Register the selected enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_en_o <= '0;
            core_en_o   <= 1'b0;
        end else begin
            periph_en_o <= periph_en_d_i;
            core_en_o   <= core_en_d_i;
        end
    end

endmodule

// File: rtl/pwr_clk_gate_sel.sv
// Module: pwr_clk_gate_sel (top)
// Produces per-peripheral clock enables and a core clock enable from the
// power mode. Each mode has its own gating bank, and writes are limited
// by CAP_MASK. Assumes 1 <= NUM_PERIPH <= 32 and a decoded mode input.
module pwr_clk_gate_sel #(
    parameter int unsigned NUM_PERIPH = 8,
    parameter logic [NUM_PERIPH-1:0] CAP_MASK = 8'hB7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  auto_gate_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_sel_i,
    input  logic [NUM_PERIPH-1:0] wr_data_i,
    input  logic [1:0]            rd_sel_i,
    output logic [NUM_PERIPH-1:0] rd_data_o,
    output logic [NUM_PERIPH-1:0] periph_en_o,
    output logic                  core_en_o
);

    logic [NUM_PERIPH-1:0] run_bank;
    logic [NUM_PERIPH-1:0] slp_bank;
    logic [NUM_PERIPH-1:0] dsl_bank;
    logic [NUM_PERIPH-1:0] periph_en_d;
    logic                  core_en_d;

    pcg_bank_regs #(
        .NUM_PERIPH (NUM_PERIPH),
        .CAP_MASK   (CAP_MASK)
    ) banks_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .run_q_o   (run_bank),
        .slp_q_o   (slp_bank),
        .dsl_q_o   (dsl_bank)
    );

    pcg_mode_mux #(
        .NUM_PERIPH (NUM_PERIPH)
    ) mux_i (
        .mode_i        (mode_i),
        .auto_gate_i   (auto_gate_i),
        .run_q_i       (run_bank),
        .slp_q_i       (slp_bank),
        .dsl_q_i       (dsl_bank),
        .periph_en_d_o (periph_en_d),
        .core_en_d_o   (core_en_d)
    );

    pcg_out_reg #(
        .NUM_PERIPH (NUM_PERIPH)
    ) oreg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .periph_en_d_i (periph_en_d),
        .core_en_d_i   (core_en_d),
        .periph_en_o   (periph_en_o),
        .core_en_o     (core_en_o)
    );

endmodule

// File: rtl/pcg_chk.sv
// Module: pcg_chk
// Assertion checker bound to pwr_clk_gate_sel. It relates the bank state
// to the registered enables one cycle later.
module pcg_chk #(
    parameter int unsigned NUM_PERIPH = 8,
    parameter logic [NUM_PERIPH-1:0] CAP_MASK = '1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            mode_i,
    input logic                  auto_gate_i,
    input logic                  wr_en_i,
    input logic [1:0]            wr_sel_i,
    input logic [NUM_PERIPH-1:0] run_bank,
    input logic [NUM_PERIPH-1:0] slp_bank,
    input logic [NUM_PERIPH-1:0] dsl_bank,
    input logic [NUM_PERIPH-1:0] periph_en_o,
    input logic                  core_en_o
);

    // R2
    run_core_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> (core_en_o && periph_en_o == $past(run_bank)));

    // R3
    lowpwr_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd0) |=> !core_en_o);

    // R4
    sleep_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && auto_gate_i) |=> (periph_en_o == $past(slp_bank)));

    // R5
    deep_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && auto_gate_i) |=> (periph_en_o == $past(dsl_bank)));

    // R6
    fallback_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd0 && !auto_gate_i) |=> (periph_en_o == $past(run_bank)));

    // R7
    cap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_bank | slp_bank | dsl_bank) & ~CAP_MASK) == '0);

    // R8
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || wr_sel_i == 2'd3) |=>
            ($stable(run_bank) && $stable(slp_bank) && $stable(dsl_bank)));

endmodule

bind pwr_clk_gate_sel pcg_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .CAP_MASK   (CAP_MASK)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .auto_gate_i (auto_gate_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .run_bank    (run_bank),
    .slp_bank    (slp_bank),
    .dsl_bank    (dsl_bank),
    .periph_en_o (periph_en_o),
    .core_en_o   (core_en_o)
);

// File: tb/pwr_clk_gate_sel_tb_top.sv
// Directed bench for pwr_clk_gate_sel. Inputs change 1 ns after a rising
// edge, and outputs are sampled at that same point.
module pwr_clk_gate_sel_tb_top;

    localparam int unsigned N   = 8;
    localparam logic [N-1:0] CAP = 8'hB7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         auto_g = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [N-1:0] rd_data;
    logic [N-1:0] periph_en;
    logic         core_en;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] mr = '0, ms = '0, md = '0;

    always #10 clk = ~clk;

    pwr_clk_gate_sel #(.NUM_PERIPH(N), .CAP_MASK(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .auto_gate_i(auto_g),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .periph_en_o(periph_en), .core_en_o(core_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_pe(input logic [1:0] m, input logic a);
        if (m == 2'd0 || !a) return mr;
        if (m == 2'd1) return ms;
        return md;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
        case (sel)
            2'd0: mr = d & CAP;
            2'd1: ms = d & CAP;
            2'd2: md = d & CAP;
            default: ;
        endcase
    endtask

    task automatic readback(input string req);
        rd_sel = 2'd0; #1; chk(req, rd_data, mr);
        rd_sel = 2'd1; #1; chk(req, rd_data, ms);
        rd_sel = 2'd2; #1; chk(req, rd_data, md);
        rd_sel = 2'd3; #1; chk(req, rd_data, '0);
    endtask

    task automatic t_reset();
        tick();
        chk("R1 periph", periph_en, '0);
        chk("R1 core", {{(N-1){1'b0}}, core_en}, '0);
        readback("R1 banks");
    endtask

    task automatic t_mask();
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'hF0);
        readback("R7 masked readback");
    endtask

    task automatic t_ignored();
        wr(2'd3, 8'h48);
        readback("R8 select 3");
        wr_data = 8'h00; wr_sel = 2'd0;
        tick();
        readback("R8 strobe low");
    endtask

    task automatic t_modes();
        mode = 2'd0; auto_g = 1'b1; tick();
        chk("R2 core run", {{(N-1){1'b0}}, core_en}, 1);
        chk("R2 periph run", periph_en, mr);
        mode = 2'd1; tick();
        chk("R3 core sleep", {{(N-1){1'b0}}, core_en}, '0);
        chk("R4 sleep bank", periph_en, exp_pe(2'd1, 1'b1));
        mode = 2'd2; tick();
        chk("R3 core deep", {{(N-1){1'b0}}, core_en}, '0);
        chk("R5 deep bank", periph_en, exp_pe(2'd2, 1'b1));
        mode = 2'd3; tick();
        chk("R5 code 3", periph_en, md);
        chk("R3 core code 3", {{(N-1){1'b0}}, core_en}, '0);
        auto_g = 1'b0; tick();
        chk("R6 deep fallback", periph_en, mr);
        mode = 2'd1; tick();
        chk("R6 sleep fallback", periph_en, mr);
    endtask

    task automatic t_overlap();
        logic [N-1:0] old;
        mode = 2'd1; auto_g = 1'b1; tick();
        old = ms;
        wr(2'd1, 8'hA4);
        chk("R9 sleep write first edge", periph_en, old);
        tick();
        chk("R9 sleep write second edge", periph_en, ms);
        old = mr;
        mode = 2'd0;
        wr(2'd0, 8'h13);
        chk("R9 run switch old bank", periph_en, old);
        chk("R2 core back on", {{(N-1){1'b0}}, core_en}, 1);
        tick();
        chk("R9 run switch new bank", periph_en, mr);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        chk("R1 after release", periph_en, '0);
        t_mask();
        t_ignored();
        t_modes();
        t_overlap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule